// File: doc/BRIEF.md
# Systolic Integer Matrix-Multiply Array

This block multiplies a stream of activation rows by a stationary square matrix of signed 8-bit weights. It is built as a DIM x DIM grid of multiply-accumulate cells. Each cell holds one weight and multiplies it by the activation that arrives from its left neighbour. It adds the product to the partial sum that arrives from the cell above, then hands both values on at the next clock. Lane i of each activation row is delayed by i cycles before it enters grid row i, so each result row builds up along a diagonal wavefront. The bottom of the grid then delays column j by DIM-j cycles, so every lane of one result row leaves the array in the same cycle.

The weights are loaded one row per clock through a shift chain that runs down the columns. This is only possible while no pass is running. A pass begins with a start pulse, which picks a base address and a write mode. The block then accepts one full activation row per clock while `a_ready` is high, and the row flagged as last closes the input side. Each result row is written exactly once, to consecutive entries of an internal accumulator bank. The mode decides whether the row replaces an entry or is added to it. A `done` pulse marks the write of the final row. The bank is read through a separate combinational port.

Top module: `systolic_mm_array`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `a_ready`, `acc_we` and `done` are 0, and every accumulator entry reads 0.
- R2: While idle, each cycle with `w_valid` high shifts the weight rows down by one. After DIM beats, the row sent in beat b (0-based) is the weight row for activation lane DIM-1-b. Lane j of `w_row` is bits [8j+7:8j] and is the weight for output column j.
- R3: A `w_valid` beat that arrives while a pass is running has no effect on any result.
- R4: `start` while idle makes `busy` and `a_ready` 1 in the next cycle and captures `start_add` and `start_base`. `start` while busy is ignored.
- R5: For each accepted row A, where lane i is bits [8i+7:8i] as signed 8-bit, output lane j (bits [32j+31:32j] of `acc_wdata`) equals the sum over i of A[i]*W[i][j], as 32-bit two's complement.
- R6: A row that is accepted in cycle t (with `a_valid` and `a_ready` both 1) appears on the write port with `acc_we` = 1 in cycle t+2*DIM. Rows come out in order, and input gaps stay gaps. There is no write at any other time.
- R7: The first row of a pass is written to `start_base`, and each later row goes to the next address, wrapping modulo ACC_DEPTH (a power of two).
- R8: With `start_add` = 0 an entry is overwritten by the row. With `start_add` = 1 the row is added lane by lane into the entry, modulo 2^32.
- R9: `a_ready` falls in the cycle after the row with `a_last` is accepted, and `a_valid` is ignored from then on until the pass ends. `done` is 1 only together with the write of that last row, and `busy` is 0 in the following cycle.
- R10: `rd_data` shows the entry at `rd_addr`. A write becomes visible there in the cycle after its `acc_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Weight row beat |
| w_row | input | DIM*8 | Weight row, one signed byte per column |
| start | input | 1 | Begin a pass |
| start_add | input | 1 | 1: add results into entries, 0: overwrite |
| start_base | input | log2(ACC_DEPTH) | First accumulator address of the pass |
| a_valid | input | 1 | Activation row offered |
| a_last | input | 1 | Marks the final row of the pass |
| a_row | input | DIM*8 | Activation row, one signed byte per lane |
| a_ready | output | 1 | Activation rows are accepted |
| busy | output | 1 | A pass is in progress |
| acc_we | output | 1 | Result row is written this cycle |
| acc_waddr | output | log2(ACC_DEPTH) | Address of the row being written |
| acc_wdata | output | DIM*32 | Result row being written |
| done | output | 1 | The final row of the pass is written |
| rd_addr | input | log2(ACC_DEPTH) | Accumulator read address |
| rd_data | output | DIM*32 | Accumulator entry at `rd_addr` |

## Verification
The properties check the pass protocol on every cycle. Busy can only rise after a start, writes and `a_ready` occur only inside a pass, and `done` always coincides with a write and is followed by idle. Consecutive writes step the address by one. The arithmetic cannot be checked this way: the signed dot products, the diagonal skew lining up, the exact 2*DIM latency, the weight placement, overwrite against add, and that junk weight, start and activation beats really are ignored. Only the bench's reference model shows these, by comparing the write port every cycle and reading back the bank after passes with gaps, wrapped addresses and extreme operands.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic {
        ACC_OVERWRITE = 1'b0,
        ACC_ADD       = 1'b1
    } acc_mode_e;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_FEED  = 2'd1,
        PS_DRAIN = 2'd2
    } pass_state_e;
endpackage

// File: rtl/sa_delay.sv
// Fixed-length register chain (DEPTH >= 1), used for input skew and output de-skew.
module sa_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < DEPTH; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/sa_mac.sv
// One grid cell: signed AW x AW product added to the incoming partial sum.
module sa_mac #(
    parameter int AW = 8,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] w,
    input  logic [AW-1:0] act_in,
    input  logic [PW-1:0] psum_in,
    output logic [PW-1:0] psum_out
);
    localparam int PRW = 2 * AW;

    logic signed [PRW-1:0] prod;
    logic [PW-1:0]         psum_d, psum_q;

    always_comb begin
        prod   = $signed(act_in) * $signed(w);
        psum_d = psum_in + {{(PW-PRW){prod[PRW-1]}}, prod};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psum_q <= '0;
        else        psum_q <= psum_d;
    end

    assign psum_out = psum_q;
endmodule

// File: rtl/sa_accbank.sv
// Accumulator storage: one row of DIM sums per entry, overwrite or add on write.
module sa_accbank
    import sa_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int PW    = 32,
    parameter int DEPTH = 8,
    localparam int ABW  = $clog2(DEPTH),
    localparam int RW   = DIM * PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [ABW-1:0] wr_addr,
    input  acc_mode_e      wr_mode,
    input  logic [RW-1:0]  wr_row,
    input  logic [ABW-1:0] rd_addr,
    output logic [RW-1:0]  rd_data
);
    logic [RW-1:0] bank_d [DEPTH];
    logic [RW-1:0] bank_q [DEPTH];

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int l = 0; l < DIM; l++) begin
                if (wr_mode == ACC_ADD)
                    bank_d[wr_addr][l*PW +: PW] = bank_q[wr_addr][l*PW +: PW] + wr_row[l*PW +: PW];
                else
                    bank_d[wr_addr][l*PW +: PW] = wr_row[l*PW +: PW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                bank_q[k] <= '0;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data = bank_q[rd_addr];
endmodule

// File: rtl/systolic_mm_array.sv
module systolic_mm_array
    import sa_pkg::*;
#(
    parameter int DIM       = 4,
    parameter int AW        = 8,
    parameter int PW        = 32,
    parameter int ACC_DEPTH = 8,
    localparam int ACC_AW   = $clog2(ACC_DEPTH),
    localparam int ROW_AW   = DIM * AW,
    localparam int ROW_PW   = DIM * PW,
    localparam int LAT      = 2 * DIM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_valid,
    input  logic [ROW_AW-1:0] w_row,
    input  logic              start,
    input  logic              start_add,
    input  logic [ACC_AW-1:0] start_base,
    input  logic              a_valid,
    input  logic              a_last,
    input  logic [ROW_AW-1:0] a_row,
    output logic              a_ready,
    output logic              busy,
    output logic              acc_we,
    output logic [ACC_AW-1:0] acc_waddr,
    output logic [ROW_PW-1:0] acc_wdata,
    output logic              done,
    input  logic [ACC_AW-1:0] rd_addr,
    output logic [ROW_PW-1:0] rd_data
);
    typedef struct packed {
        pass_state_e                       st;
        acc_mode_e                         mode;
        logic [ACC_AW-1:0]                 wptr;
        logic [LAT-1:0]                    vpipe;
        logic [LAT-1:0]                    lpipe;
        logic [DIM-1:0][DIM-1:0][AW-1:0]   w;
        logic [DIM-1:0][DIM-2:0][AW-1:0]   act;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          accept, load;
    logic [AW-1:0] act_gated    [DIM];
    logic [AW-1:0] skew_out     [DIM];
    logic [AW-1:0] cell_act     [DIM][DIM];
    logic [PW-1:0] cell_psum_in [DIM][DIM];
    logic [PW-1:0] cell_psum    [DIM][DIM];
    logic [PW-1:0] col_out      [DIM];

    assign accept = a_valid && (r_q.st == PS_FEED);
    assign load   = w_valid && (r_q.st == PS_IDLE);

    for (genvar gi = 0; gi < DIM; gi++) begin : g_row
        assign act_gated[gi] = accept ? a_row[gi*AW +: AW] : '0;

        if (gi == 0) begin : g_noskew
            assign skew_out[gi] = act_gated[gi];
        end else begin : g_skew
            sa_delay #(.W(AW), .DEPTH(gi)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (act_gated[gi]),
                .dout (skew_out[gi])
            );
        end

        for (genvar gj = 0; gj < DIM; gj++) begin : g_col
            if (gj == 0) begin : g_act_edge
                assign cell_act[gi][gj] = skew_out[gi];
            end else begin : g_act_inner
                assign cell_act[gi][gj] = r_q.act[gi][gj-1];
            end

            if (gi == 0) begin : g_ps_edge
                assign cell_psum_in[gi][gj] = '0;
            end else begin : g_ps_inner
                assign cell_psum_in[gi][gj] = cell_psum[gi-1][gj];
            end

            sa_mac #(.AW(AW), .PW(PW)) u_mac (
                .clk     (clk),
                .rst_n   (rst_n),
                .w       (r_q.w[gi][gj]),
                .act_in  (cell_act[gi][gj]),
                .psum_in (cell_psum_in[gi][gj]),
                .psum_out(cell_psum[gi][gj])
            );
        end
    end

    for (genvar gj = 0; gj < DIM; gj++) begin : g_deskew
        sa_delay #(.W(PW), .DEPTH(DIM - gj)) u_deskew (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cell_psum[DIM-1][gj]),
            .dout (col_out[gj])
        );
        assign acc_wdata[gj*PW +: PW] = col_out[gj];
    end

    assign acc_we    = r_q.vpipe[LAT-1];
    assign done      = r_q.vpipe[LAT-1] & r_q.lpipe[LAT-1];
    assign acc_waddr = r_q.wptr;
    assign a_ready   = (r_q.st == PS_FEED);
    assign busy      = (r_q.st != PS_IDLE);

    always_comb begin
        r_d       = r_q;
        r_d.vpipe = {r_q.vpipe[LAT-2:0], accept};
        r_d.lpipe = {r_q.lpipe[LAT-2:0], accept & a_last};

        unique case (r_q.st)
            PS_IDLE: begin
                if (start) begin
                    r_d.st   = PS_FEED;
                    r_d.mode = acc_mode_e'(start_add);
                    r_d.wptr = start_base;
                end
            end
            PS_FEED: begin
                if (accept && a_last) r_d.st = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (done) r_d.st = PS_IDLE;
            end
            default: r_d.st = PS_IDLE;
        endcase

        if (acc_we) r_d.wptr = r_q.wptr + ACC_AW'(1);

        if (load) begin
            for (int j = 0; j < DIM; j++) begin
                r_d.w[0][j] = w_row[j*AW +: AW];
            end
            for (int i = 1; i < DIM; i++) begin
                r_d.w[i] = r_q.w[i-1];
            end
        end

        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM - 1; j++) begin
                r_d.act[i][j] = cell_act[i][j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    sa_accbank #(.DIM(DIM), .PW(PW), .DEPTH(ACC_DEPTH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_we),
        .wr_addr(r_q.wptr),
        .wr_mode(r_q.mode),
        .wr_row (acc_wdata),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
    parameter int AAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           a_ready,
    input logic           acc_we,
    input logic [AAW-1:0] acc_waddr,
    input logic           done
);
    a_r4_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_ready_inside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> busy);

    a_r6_write_inside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> busy);

    a_r9_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acc_we);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && $past(acc_we)) |-> (acc_waddr == $past(acc_waddr) + AAW'(1)));
endmodule

bind systolic_mm_array sa_checker #(.AAW(ACC_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .a_ready  (a_ready),
    .acc_we   (acc_we),
    .acc_waddr(acc_waddr),
    .done     (done)
);

// File: tb/tb_systolic_mm_array.sv
`timescale 1ns/100ps
module tb_systolic_mm_array;
    localparam int DIM = 4, AW = 8, PW = 32, DEPTH = 8, AAW = 3, LAT = 2 * DIM;

    logic                clk = 1'b0, rst_n = 1'b0;
    logic                w_valid = 1'b0, start = 1'b0, start_add = 1'b0;
    logic                a_valid = 1'b0, a_last = 1'b0;
    logic [DIM*AW-1:0]   w_row = '0, a_row = '0;
    logic [AAW-1:0]      start_base = '0, rd_addr = '0;
    logic                a_ready, busy, acc_we, done;
    logic [AAW-1:0]      acc_waddr;
    logic [DIM*PW-1:0]   acc_wdata, rd_data;

    systolic_mm_array #(.DIM(DIM), .AW(AW), .PW(PW), .ACC_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_row(w_row),
        .start(start), .start_add(start_add), .start_base(start_base),
        .a_valid(a_valid), .a_last(a_last), .a_row(a_row),
        .a_ready(a_ready), .busy(busy), .acc_we(acc_we), .acc_waddr(acc_waddr),
        .acc_wdata(acc_wdata), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0, checks = 0;
    bit mon_on = 1'b0;
    int wref  [DIM][DIM];
    int wnext [DIM][DIM];
    int arow  [DIM];
    logic [PW-1:0] mem [DEPTH][DIM];

    int              q_t[$];
    int              q_addr[$];
    logic [DIM*PW-1:0] q_data[$];
    bit              q_last[$];
    bit              q_add[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, actv, expv, cyc);
        end
    endtask

    // Reference write-port model, compared every cycle (R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (mon_on) begin
            if (q_t.size() > 0 && q_t[0] == cyc) begin
                check(acc_we == 1'b1, "R6", "acc_we at expected cycle", acc_we, 1);
                check(acc_waddr == AAW'(q_addr[0]), "R7", "write address", acc_waddr, q_addr[0]);
                for (int l = 0; l < DIM; l++)
                    check(acc_wdata[l*PW +: PW] == q_data[0][l*PW +: PW], "R5", "result lane",
                          $signed(acc_wdata[l*PW +: PW]), $signed(q_data[0][l*PW +: PW]));
                check(done == q_last[0], "R9", "done with last write", done, q_last[0]);
                for (int l = 0; l < DIM; l++)
                    mem[q_addr[0]][l] = q_add[0] ? mem[q_addr[0]][l] + q_data[0][l*PW +: PW]
                                                 : q_data[0][l*PW +: PW];
                void'(q_t.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
                void'(q_last.pop_front()); void'(q_add.pop_front());
            end else begin
                check(acc_we == 1'b0 && done == 1'b0, "R6", "no write outside schedule",
                      {acc_we, done}, 0);
            end
        end
    end

    task automatic load_weights();
        for (int b = 0; b < DIM; b++) begin
            @(negedge clk);
            w_valid = 1'b1;
            for (int j = 0; j < DIM; j++) w_row[j*AW +: AW] = wnext[DIM-1-b][j][AW-1:0];
        end
        @(negedge clk);
        w_valid = 1'b0;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) wref[i][j] = wnext[i][j];
    endtask

    task automatic check_bank(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_addr = AAW'(a);
            #0.5;
            for (int l = 0; l < DIM; l++)
                check(rd_data[l*PW +: PW] == mem[a][l], req, "accumulator entry",
                      $signed(rd_data[l*PW +: PW]), $signed(mem[a][l]));
        end
    endtask

    task automatic run_pass(input bit add, input int base, input int nrows,
                            input bit gaps, input int seed);
        logic [DIM*PW-1:0] expv;
        int s;
        @(negedge clk);
        start = 1'b1; start_add = add; start_base = AAW'(base);
        @(negedge clk);
        start = 1'b0;
        check(a_ready == 1'b1 && busy == 1'b1, "R4", "ready after start", {a_ready, busy}, 3);
        for (int r = 0; r < nrows; r++) begin
            for (int i = 0; i < DIM; i++) begin
                if (seed == 0 && r == 0)      arow[i] = -128;
                else if (seed == 0 && r == 1) arow[i] = 127;
                else arow[i] = ((r * 37 + i * 53 + seed * 71 + 11) % 256) - 128;
                a_row[i*AW +: AW] = arow[i][AW-1:0];
            end
            for (int j = 0; j < DIM; j++) begin
                s = 0;
                for (int i = 0; i < DIM; i++) s += arow[i] * wref[i][j];
                expv[j*PW +: PW] = s;
            end
            a_valid = 1'b1;
            a_last  = (r == nrows - 1);
            q_t.push_back(cyc + LAT); q_addr.push_back((base + r) % DEPTH);
            q_data.push_back(expv); q_last.push_back(r == nrows - 1); q_add.push_back(add);
            // R4: a start pulse during the pass must not move base or mode
            start = (r == 1); start_add = ~add; start_base = AAW'(base + 3);
            @(negedge clk);
            start = 1'b0;
            if (gaps && (r % 2 == 0) && r != nrows - 1) begin
                a_valid = 1'b0;
                @(negedge clk);
            end
        end
        a_valid = 1'b0; a_last = 1'b0;
        @(negedge clk);
        check(a_ready == 1'b0, "R9", "ready drops after last", a_ready, 0);
        // R9 ignored activation beats, R3 ignored weight beat, R4 ignored start
        a_valid = 1'b1; a_row = '1; w_valid = 1'b1; w_row = 32'h7f01_80ff;
        start = 1'b1; start_base = AAW'(base + 1);
        @(negedge clk);
        a_valid = 1'b0; w_valid = 1'b0; start = 1'b0;
        for (int k = 0; k < 100 && q_t.size() > 0; k++) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R9", "idle after done", busy, 0);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++)
            for (int l = 0; l < DIM; l++) mem[a][l] = '0;
        repeat (3) @(negedge clk);
        check(busy == 0 && a_ready == 0 && acc_we == 0 && done == 0, "R1", "outputs in reset",
              {busy, a_ready, acc_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && a_ready == 0 && acc_we == 0 && done == 0, "R1", "outputs after reset",
              {busy, a_ready, acc_we, done}, 0);
        mon_on = 1'b1;
        check_bank("R1");

        // R2: first weight set with both extremes
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) wnext[i][j] = (((i * DIM + j) * 29 + 5) % 256) - 128;
        wnext[0][0] = -128; wnext[DIM-1][DIM-1] = 127;
        load_weights();

        run_pass(1'b0, 2, 5, 1'b0, 0);   // R5 R8 overwrite, extreme rows
        check_bank("R10");
        run_pass(1'b1, 6, 4, 1'b1, 1);   // R7 wrap, R8 add, R6 gaps, R3 old weights kept
        check_bank("R8");

        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) wnext[i][j] = ((i * 61 + j * 17 + 90) % 256) - 128;
        load_weights();                  // R2 second set
        run_pass(1'b1, 3, 3, 1'b0, 2);
        run_pass(1'b0, 7, 1, 1'b0, 3);   // R9 single-row pass
        check_bank("R8");

        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule